// File: doc/BRIEF.md
# TLB Refill Page-Table Walker

This block services a translation miss without software help. When the miss interface hands it a faulting virtual address, it forms the virtual address of the matching page-table entry from the table base register. It then asks the TLB to translate that address with refill disabled, so a miss on the table address cannot start a nested walk. If the translation hits, the walker reads the 32-bit entry from memory and writes it into one of the refillable ways. If it fails, the walker reports the translation's cause code as a fault and writes nothing.

One walk runs at a time. The walker accepts a request only while it is idle. The memory read request follows valid/ready rules: once `mem_req_valid` is raised, the request and its address stay fixed until `mem_req_ready` is sampled high. The read response has no back-pressure, because the walker always waits in a state that is ready for it. The translation port answers in the same cycle: `xlat_req` is high for exactly one cycle, and the hit flag, physical address and cause are sampled at the end of that cycle.

The way that receives each new entry comes from a small counter, which is pre-incremented on each successful refill. After a refill completes, the faulting address is held in an exception-address register that can be observed as an output.

Top module: `tlb_refill_walker`

## Requirements
- R1: After reset the walker is idle: `miss_ready`=1, `tlb_wr_en`=0, `mem_req_valid`=0, `done`=0, `fault`=0, `exc_vaddr`=0. The refill way counter starts at 0, so the first successful refill uses way 1.
- R2: One cycle after a request is accepted, `xlat_req`=1 and `xlat_vaddr` = (`pt_base` OR (`miss_vaddr` >> 10)) with bits 1:0 forced to 0. Both `pt_base` and `miss_vaddr` are the values captured at acceptance.
- R3: If `xlat_hit`=0 in the translate cycle, the next cycle has `fault`=1 and `fault_cause` equal to the `xlat_cause` that was sampled. In that case no memory request and no TLB write occur, `exc_vaddr` is unchanged, and the walker is idle again one cycle later.
- R4: On a hit, the next cycle raises `mem_req_valid` with `mem_req_addr` equal to the sampled `xlat_paddr`. Both stay stable until a cycle where `mem_req_ready`=1, and `mem_req_valid` drops after that cycle.
- R5: The walker waits any number of cycles for `mem_rsp_valid`. In the cycle after the response, `tlb_wr_en`=1 for one cycle, with `tlb_wr_pte` equal to the response data and `tlb_wr_ring` equal to bits 5:4 of that data.
- R6: Successful refills write ways 1, 2, 3, 0, 1, … in turn (way = low two bits of the pre-incremented counter). A faulted walk does not advance the counter.
- R7: After a successful refill, `exc_vaddr` holds that walk's faulting virtual address, and `tlb_wr_vaddr` carries the same address during the write.
- R8: `miss_ready` is 1 only in idle. Changes on `miss_vaddr`, `pt_base` or `miss_valid` during a walk do not affect it.
- R9: `done`=1 for exactly the one cycle after the TLB write, and the walker is idle in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle, request accepted |
| miss_vaddr | input | 32 | Faulting virtual address |
| pt_base | input | 32 | Page-table base register |
| xlat_req | output | 1 | Translation lookup for the table address |
| xlat_vaddr | output | 32 | Table-entry virtual address to translate |
| xlat_hit | input | 1 | Lookup succeeded |
| xlat_paddr | input | 32 | Physical address of the table entry |
| xlat_cause | input | 6 | Cause code when the lookup fails |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Physical read address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Fetched table entry |
| tlb_wr_en | output | 1 | TLB write strobe |
| tlb_wr_way | output | 2 | Target refill way |
| tlb_wr_vaddr | output | 32 | Faulting virtual address for the new entry |
| tlb_wr_pte | output | 32 | Table entry to install |
| tlb_wr_ring | output | 2 | Ring taken from entry bits 5:4 |
| exc_vaddr | output | 32 | Exception-address register |
| done | output | 1 | Refill finished |
| fault | output | 1 | Walk aborted on a failed translation |
| fault_cause | output | 6 | Cause code of the failed translation |

## Verification
The hardest situation to reach is a walk where memory back-pressure and a late response overlap with new values on the request inputs, while the way counter is at its wrap point. The bench sweeps forty walks. Each walk uses its own request-ready delay and response delay. On alternate walks, `miss_valid` stays high with changed address and base during the walk, and some walks in between are failed translations. This checks that the way sequence wraps and skips faulted walks, and that the captured address is the one that appears in `exc_vaddr`.

// File: rtl/walker_pkg.sv
package walker_pkg;
  typedef enum logic [2:0] {
    W_IDLE,
    W_XLATE,
    W_RDREQ,
    W_RDWAIT,
    W_WRITE,
    W_DONE,
    W_FAULT
  } walk_state_e;
endpackage

// File: rtl/pte_addr_gen.sv
module pte_addr_gen #(
  parameter int AW    = 32,
  parameter int SHIFT = 10
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] vaddr,
  output logic [AW-1:0] pte_vaddr
);
  localparam logic [AW-1:0] WORD_MASK = ~AW'(3);
  assign pte_vaddr = (base | (vaddr >> SHIFT)) & WORD_MASK;
endmodule

// File: rtl/refill_way_ctr.sv
module refill_way_ctr #(
  parameter int WAYS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      advance,
  output logic [$clog2(WAYS)-1:0]   next_way
);
  localparam int WW = $clog2(WAYS);
  logic [WW-1:0] cnt_q;

  // pre-increment: the way used is the counter value after stepping
  assign next_way = cnt_q + WW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (advance) cnt_q <= next_way;
  end
endmodule

// File: rtl/tlb_refill_walker.sv
module tlb_refill_walker #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int CAUSE_W     = 6,
  parameter int PTE_SHIFT   = 10,
  parameter int REFILL_WAYS = 4,
  parameter int RING_LSB    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           miss_valid,
  output logic                           miss_ready,
  input  logic [AW-1:0]                  miss_vaddr,
  input  logic [AW-1:0]                  pt_base,
  output logic                           xlat_req,
  output logic [AW-1:0]                  xlat_vaddr,
  input  logic                           xlat_hit,
  input  logic [AW-1:0]                  xlat_paddr,
  input  logic [CAUSE_W-1:0]             xlat_cause,
  output logic                           mem_req_valid,
  input  logic                           mem_req_ready,
  output logic [AW-1:0]                  mem_req_addr,
  input  logic                           mem_rsp_valid,
  input  logic [DW-1:0]                  mem_rsp_data,
  output logic                           tlb_wr_en,
  output logic [$clog2(REFILL_WAYS)-1:0] tlb_wr_way,
  output logic [AW-1:0]                  tlb_wr_vaddr,
  output logic [DW-1:0]                  tlb_wr_pte,
  output logic [1:0]                     tlb_wr_ring,
  output logic [AW-1:0]                  exc_vaddr,
  output logic                           done,
  output logic                           fault,
  output logic [CAUSE_W-1:0]             fault_cause
);
  import walker_pkg::*;

  walk_state_e         st_q, st_d;
  logic [AW-1:0]       va_q, base_q, pa_q, exc_q;
  logic [DW-1:0]       pte_q;
  logic [CAUSE_W-1:0]  cause_q;
  logic                accept, wr_fire;

  assign accept  = miss_valid && (st_q == W_IDLE);
  assign wr_fire = (st_q == W_WRITE);

  pte_addr_gen #(.AW(AW), .SHIFT(PTE_SHIFT)) u_addr (
    .base(base_q), .vaddr(va_q), .pte_vaddr(xlat_vaddr)
  );

  refill_way_ctr #(.WAYS(REFILL_WAYS)) u_way (
    .clk(clk), .rst_n(rst_n), .advance(wr_fire), .next_way(tlb_wr_way)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      W_IDLE:   if (miss_valid) st_d = W_XLATE;
      W_XLATE:  st_d = xlat_hit ? W_RDREQ : W_FAULT;
      W_RDREQ:  if (mem_req_ready) st_d = W_RDWAIT;
      W_RDWAIT: if (mem_rsp_valid) st_d = W_WRITE;
      W_WRITE:  st_d = W_DONE;
      W_DONE:   st_d = W_IDLE;
      W_FAULT:  st_d = W_IDLE;
      default:  st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      pte_q   <= '0;
      cause_q <= '0;
      exc_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        va_q   <= miss_vaddr;
        base_q <= pt_base;
      end
      if (st_q == W_XLATE) begin
        pa_q    <= xlat_paddr;
        cause_q <= xlat_cause;
      end
      if (st_q == W_RDWAIT && mem_rsp_valid) pte_q <= mem_rsp_data;
      if (wr_fire) exc_q <= va_q;
    end
  end

  assign miss_ready    = (st_q == W_IDLE);
  assign xlat_req      = (st_q == W_XLATE);
  assign mem_req_valid = (st_q == W_RDREQ);
  assign mem_req_addr  = pa_q;
  assign tlb_wr_en     = wr_fire;
  assign tlb_wr_vaddr  = va_q;
  assign tlb_wr_pte    = pte_q;
  assign tlb_wr_ring   = pte_q[RING_LSB +: 2];
  assign exc_vaddr     = exc_q;
  assign done          = (st_q == W_DONE);
  assign fault         = (st_q == W_FAULT);
  assign fault_cause   = cause_q;
endmodule

// File: rtl/tlb_refill_walker_chk.sv
module tlb_refill_walker_chk #(
  parameter int AW   = 32,
  parameter int WAYS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    miss_ready,
  input logic                    xlat_req,
  input logic [AW-1:0]           xlat_vaddr,
  input logic                    mem_req_valid,
  input logic                    mem_req_ready,
  input logic [AW-1:0]           mem_req_addr,
  input logic                    tlb_wr_en,
  input logic [$clog2(WAYS)-1:0] tlb_wr_way,
  input logic [AW-1:0]           tlb_wr_vaddr,
  input logic [AW-1:0]           exc_vaddr,
  input logic                    done,
  input logic                    fault
);
  localparam int WW = $clog2(WAYS);
  logic [WW-1:0] last_way_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         last_way_q <= '0;
    else if (tlb_wr_en) last_way_q <= tlb_wr_way;
  end

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req |-> (xlat_vaddr[1:0] == 2'b00));

  assert_no_write_on_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!tlb_wr_en && !mem_req_valid));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_way_rotation_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr_en |-> (tlb_wr_way == WW'(last_way_q + WW'(1))));

  assert_exc_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr_en |=> (exc_vaddr == $past(tlb_wr_vaddr)));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req || mem_req_valid || tlb_wr_en || done || fault) |-> !miss_ready);

  assert_done_follows_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr_en |=> (done && !tlb_wr_en));
endmodule

bind tlb_refill_walker tlb_refill_walker_chk #(.AW(AW), .WAYS(REFILL_WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_ready(miss_ready), .xlat_req(xlat_req),
  .xlat_vaddr(xlat_vaddr), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .tlb_wr_en(tlb_wr_en), .tlb_wr_way(tlb_wr_way),
  .tlb_wr_vaddr(tlb_wr_vaddr), .exc_vaddr(exc_vaddr), .done(done), .fault(fault)
);

// File: tb/sim_tlb_refill_walker.sv
module sim_tlb_refill_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        miss_valid = 0, miss_ready;
  logic [31:0] miss_vaddr = 0, pt_base = 0;
  logic        xlat_req;
  logic [31:0] xlat_vaddr;
  logic        xlat_hit = 0;
  logic [31:0] xlat_paddr = 0;
  logic [5:0]  xlat_cause = 0;
  logic        mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        tlb_wr_en;
  logic [1:0]  tlb_wr_way, tlb_wr_ring;
  logic [31:0] tlb_wr_vaddr, tlb_wr_pte, exc_vaddr;
  logic        done, fault;
  logic [5:0]  fault_cause;

  tlb_refill_walker u0 (.*);

  int total = 0, bad = 0;
  logic [1:0]  exp_way = 2'd0;
  logic [31:0] exp_exc = 32'd0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit hit,
                      input logic [31:0] pa, input logic [5:0] cause, input logic [31:0] pte,
                      input int rdy_dly, input int rsp_dly, input bit hold);
    logic [31:0] pva;
    pva = (base | (va >> 10)) & 32'hFFFF_FFFC;
    miss_valid = 1; miss_vaddr = va; pt_base = base;
    xlat_hit = hit; xlat_paddr = pa; xlat_cause = cause;
    chk(miss_ready == 1, "R8 ready in idle", {31'd0, miss_ready}, 1);
    @(posedge clk); @(negedge clk);
    if (hold) begin miss_vaddr = ~va; pt_base = ~base; end
    else miss_valid = 0;
    chk(xlat_req == 1 && xlat_vaddr == pva, "R2 table address", xlat_vaddr, pva);
    chk(miss_ready == 0, "R8 busy", {31'd0, miss_ready}, 0);
    @(posedge clk); @(negedge clk);
    if (!hit) begin
      chk(fault == 1 && fault_cause == cause, "R3 fault cause", {26'd0, fault_cause}, {26'd0, cause});
      chk(tlb_wr_en == 0 && mem_req_valid == 0, "R3 no side effect", {30'd0, tlb_wr_en, mem_req_valid}, 0);
      miss_valid = 0;
      @(posedge clk); @(negedge clk);
      chk(miss_ready == 1 && fault == 0, "R3 back to idle", {31'd0, miss_ready}, 1);
      chk(exc_vaddr == exp_exc, "R3 exc unchanged", exc_vaddr, exp_exc);
      return;
    end
    for (int k = 0; k < rdy_dly; k++) begin
      chk(mem_req_valid == 1 && mem_req_addr == pa, "R4 request held", mem_req_addr, pa);
      @(posedge clk); @(negedge clk);
    end
    chk(mem_req_valid == 1 && mem_req_addr == pa, "R4 request addr", mem_req_addr, pa);
    mem_req_ready = 1;
    @(posedge clk); @(negedge clk);
    mem_req_ready = 0;
    chk(mem_req_valid == 0, "R4 request dropped", {31'd0, mem_req_valid}, 0);
    for (int k = 0; k < rsp_dly; k++) begin
      chk(tlb_wr_en == 0, "R5 waits for data", {31'd0, tlb_wr_en}, 0);
      @(posedge clk); @(negedge clk);
    end
    mem_rsp_valid = 1; mem_rsp_data = pte;
    @(posedge clk); @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_data = 32'hDEAD_BEEF;
    exp_way = exp_way + 2'd1;
    chk(tlb_wr_en == 1 && tlb_wr_pte == pte, "R5 write data", tlb_wr_pte, pte);
    chk(tlb_wr_ring == pte[5:4], "R5 ring", {30'd0, tlb_wr_ring}, {30'd0, pte[5:4]});
    chk(tlb_wr_way == exp_way, "R6 way", {30'd0, tlb_wr_way}, {30'd0, exp_way});
    chk(tlb_wr_vaddr == va, "R7 write vaddr", tlb_wr_vaddr, va);
    @(posedge clk); @(negedge clk);
    exp_exc = va;
    chk(done == 1 && tlb_wr_en == 0, "R9 done pulse", {31'd0, done}, 1);
    chk(exc_vaddr == va, "R7 exc register", exc_vaddr, va);
    miss_valid = 0;
    @(posedge clk); @(negedge clk);
    chk(done == 0 && miss_ready == 1, "R9 idle after done", {31'd0, miss_ready}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(miss_ready == 1 && tlb_wr_en == 0 && mem_req_valid == 0, "R1 reset idle", {31'd0, miss_ready}, 1);
    chk(done == 0 && fault == 0 && exc_vaddr == 0, "R1 reset status", exc_vaddr, 0);
    walk(32'hFFFF_FFFF, 32'h0, 1, 32'h1000, 6'd0, 32'h0000_0030, 0, 0, 0);
    walk(32'h0000_0000, 32'hFFC0_0000, 1, 32'h2000, 6'd0, 32'h0000_0010, 1, 2, 0);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] va, base;
      va   = 32'h9E37_79B9 * (i + 1);
      base = {i[9:0], 22'd0};
      walk(va, base, (i % 5) != 3, 32'h0010_0000 + i * 4, 6'(i + 2),
           {va[31:8], i[1:0], 2'b00, 4'h7}, i % 3, (i * 7) % 4, i[0]);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule